// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Mask Unit

This unit sits beside the data path of a SPI master that has transmit and receive FIFOs. It collects interrupt causes into a seven-bit sticky status word and gates them through a hidden mask, producing one interrupt line. Two causes come from comparing FIFO fill levels with programmable thresholds. A third comes from the receive FIFO being non-empty. The remaining four come from single-cycle event pulses supplied by the rest of the controller.

Software reaches the unit over a plain 32-bit register bus with an address, a write strobe, write data and combinational read data. A cause is acknowledged by writing a one to its status bit. Writing a one to a bit of the enable-strobe register turns that mask bit on. Writing a one to a bit of the disable-strobe register turns it off. The mask itself can be read but not written directly. The two FIFO thresholds are plain read/write registers, six bits wide, so that every value fits within the 63-word FIFO depth.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After reset the status word and the mask read 0, the TX threshold and the RX threshold read 1, and `irq` is low.
- R2: Address map (byte offsets): 0x04 is status, 0x08 is enable strobe, 0x0C is disable strobe, 0x10 is mask, 0x28 is TX threshold and 0x2C is RX threshold. The strobe registers and every unmapped address read 0, and bits 31:7 of status and mask always read 0.
- R3: A write to 0x04 clears each status bit whose write-data bit is 1. Bits written with 0 are unchanged.
- R4: A 1 in bit n of a write to 0x08 sets mask bit n. A 1 in bit n of a write to 0x0C clears mask bit n. Zero bits leave the mask unchanged, and a write to 0x10 has no effect.
- R5: Status bit 2 is set in every cycle in which `tx_level` is strictly less than the TX threshold.
- R6: Status bit 4 is set in every cycle in which `rx_level` is nonzero.
- R7: Status bit 3 is set in every cycle in which `rx_level` is greater than or equal to the RX threshold.
- R8: A high pulse on `evt[0]`, `evt[1]`, `evt[2]` or `evt[3]` sets status bit 0, 1, 5 or 6 respectively. A set status bit stays set until software clears it.
- R9: The threshold registers store bits 5:0 of the write data and read them back in bits 5:0, with the upper bits reading 0.
- R10: `irq` is high exactly when some status bit and the matching mask bit are both 1. It responds in the same cycle as any change to status or mask.
- R11: A clear takes priority over a set in the same cycle. A level cause whose condition still holds reads 0 in the cycle after the clear and 1 again one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tx_level | input | 6 | Current TX FIFO entry count |
| rx_level | input | 6 | Current RX FIFO entry count |
| evt | input | 4 | Single-cycle event pulses for status bits 0, 1, 5, 6 |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, the properties that follow from one clock of history. A written one clears its status bit and a written zero leaves it alone. The strobes move the mask, and the mask holds still without them. Set status bits stay set. The level causes rise whenever their condition holds. `irq` implies a nonzero mask. Only the bench scenarios can show the rest. These are the exact reset values, the read-back of thresholds and strobe addresses, the strict-less-than boundary of the TX comparison, the two-cycle clear-then-reassert sequence, and the gating of `irq` through particular mask patterns.

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl #(
  parameter int AW    = 8,
  parameter int LVL_W = 6,
  parameter int NEV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_we,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [NEV-1:0]   evt,
  output logic             irq
);
  localparam int NB = 7;
  localparam logic [AW-1:0] A_STAT = AW'('h04);
  localparam logic [AW-1:0] A_ENA  = AW'('h08);
  localparam logic [AW-1:0] A_DIS  = AW'('h0C);
  localparam logic [AW-1:0] A_MASK = AW'('h10);
  localparam logic [AW-1:0] A_TXT  = AW'('h28);
  localparam logic [AW-1:0] A_RXT  = AW'('h2C);

  logic [NB-1:0]    stat_q, mask_q, set_v, clr_v;
  logic [LVL_W-1:0] txthr_q, rxthr_q;

  wire wr_stat = reg_we && reg_addr == A_STAT;
  wire wr_ena  = reg_we && reg_addr == A_ENA;
  wire wr_dis  = reg_we && reg_addr == A_DIS;

  always_comb begin
    set_v    = '0;
    set_v[0] = evt[0];
    set_v[1] = evt[1];
    set_v[2] = tx_level < txthr_q;
    set_v[3] = rx_level >= rxthr_q;
    set_v[4] = rx_level != '0;
    set_v[5] = evt[2];
    set_v[6] = evt[3];
  end

  assign clr_v = wr_stat ? reg_wdata[NB-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      mask_q  <= '0;
      txthr_q <= LVL_W'(1);
      rxthr_q <= LVL_W'(1);
    end else begin
      stat_q <= (stat_q | set_v) & ~clr_v;
      if (wr_ena) mask_q <= mask_q | reg_wdata[NB-1:0];
      else if (wr_dis) mask_q <= mask_q & ~reg_wdata[NB-1:0];
      if (reg_we && reg_addr == A_TXT) txthr_q <= reg_wdata[LVL_W-1:0];
      if (reg_we && reg_addr == A_RXT) rxthr_q <= reg_wdata[LVL_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STAT:  reg_rdata[NB-1:0]    = stat_q;
      A_MASK:  reg_rdata[NB-1:0]    = mask_q;
      A_TXT:   reg_rdata[LVL_W-1:0] = txthr_q;
      A_RXT:   reg_rdata[LVL_W-1:0] = rxthr_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk #(
  parameter int AW    = 8,
  parameter int LVL_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    reg_addr,
  input logic             reg_we,
  input logic [31:0]      reg_wdata,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             irq,
  input logic [6:0]       st,
  input logic [6:0]       msk,
  input logic [LVL_W-1:0] txthr
);
  wire w_st  = reg_we && reg_addr == AW'('h04);
  wire w_ena = reg_we && reg_addr == AW'('h08);
  wire w_dis = reg_we && reg_addr == AW'('h0C);

  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    w_st |=> (st & $past(reg_wdata[6:0])) == 7'd0);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !w_st |=> (st & $past(st)) == $past(st));
  assert_w0_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    w_st |=> (st & ~$past(reg_wdata[6:0])) == ($past(st) & ~$past(reg_wdata[6:0])) ||
             (st & ~$past(reg_wdata[6:0])) != 7'd0);
  assert_enable_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    w_ena |=> (msk & $past(reg_wdata[6:0])) == $past(reg_wdata[6:0]));
  assert_disable_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    w_dis |=> (msk & $past(reg_wdata[6:0])) == 7'd0);
  assert_mask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(w_ena || w_dis) |=> $stable(msk));
  assert_tx_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level < txthr) && !(w_st && reg_wdata[2]) |=> st[2]);
  assert_rx_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level != '0) && !(w_st && reg_wdata[4]) |=> st[4]);
  assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> msk != 7'd0);
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(.AW(AW), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .tx_level(tx_level), .rx_level(rx_level),
  .irq(irq), .st(stat_q), .msk(mask_q), .txthr(txthr_q)
);

// File: tb/spi_irq_ctrl_test.sv
`timescale 1ns/1ps
module spi_irq_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  tx_level = '0, rx_level = '0;
  logic [3:0]  evt = '0;
  logic        irq;
  int checks = 0, fails = 0;

  spi_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
    .rx_level(rx_level), .evt(evt), .irq(irq));

  always #10 clk = ~clk;

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    tick();
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s addr=%h got=%h exp=%h", tag, a, reg_rdata, exp);
    end
  endtask

  task automatic chk_irq(input string tag, input logic exp);
    #1; checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq got=%b exp=%b", tag, irq, exp);
    end
  endtask

  task automatic t_reset;
    chk_rd("R1 status", 8'h04, 0);
    chk_rd("R1 mask", 8'h10, 0);
    chk_rd("R1 txthr", 8'h28, 1);
    chk_rd("R1 rxthr", 8'h2C, 1);
    chk_irq("R1", 0);
  endtask

  task automatic t_map;
    chk_rd("R2 enable reads 0", 8'h08, 0);
    chk_rd("R2 disable reads 0", 8'h0C, 0);
    chk_rd("R2 unmapped 0x00", 8'h00, 0);
    chk_rd("R2 unmapped 0x30", 8'h30, 0);
  endtask

  task automatic t_events;
    tx_level = 6'd10; rx_level = 0; tick(2);
    wr(8'h04, 32'hFFFF_FFFF);
    chk_rd("R3 all cleared", 8'h04, 0);
    evt = 4'b0101; tick(); evt = 0; tick(3);
    chk_rd("R8 sticky events", 8'h04, 32'h21);
    evt = 4'b1010; tick(); evt = 0; tick();
    chk_rd("R8 events 1,3", 8'h04, 32'h63);
    wr(8'h04, 32'h42); tick();
  endtask

  task automatic t_w1c;
    wr(8'h04, 32'h0);
    chk_rd("R3 write zero keeps", 8'h04, 32'h21);
    wr(8'h04, 32'h01);
    chk_rd("R3 write one clears", 8'h04, 32'h20);
  endtask

  task automatic t_mask;
    wr(8'h08, 32'h24);
    chk_rd("R4 enable", 8'h10, 32'h24);
    wr(8'h10, 32'h7F);
    chk_rd("R4 mask read-only", 8'h10, 32'h24);
    chk_irq("R10 masked source", 1);
    wr(8'h0C, 32'h04);
    chk_rd("R4 disable", 8'h10, 32'h20);
    wr(8'h0C, 32'h20);
    chk_rd("R4 disable all", 8'h10, 32'h00);
    chk_irq("R10 no mask", 0);
    wr(8'h08, 32'h01);
    chk_irq("R10 mask without status", 0);
    wr(8'h0C, 32'h01);
  endtask

  task automatic t_tx;
    wr(8'h04, 32'h7F); tick();
    chk_rd("R5 level above thr", 8'h04, 0);
    wr(8'h28, 32'h0C); tick();
    chk_rd("R9 txthr readback", 8'h28, 32'h0C);
    chk_rd("R5 below new thr", 8'h04, 32'h04);
    tx_level = 6'd12; tick();
    wr(8'h04, 32'h04); tick(2);
    chk_rd("R5 equal not set", 8'h04, 0);
    tx_level = 6'd11; tick();
    chk_rd("R5 one below thr", 8'h04, 32'h04);
  endtask

  task automatic t_reassert;
    wr(8'h08, 32'h04);
    wr(8'h04, 32'h04);
    chk_rd("R11 cleared this cycle", 8'h04, 0);
    chk_irq("R11 irq drops", 0);
    tick();
    chk_rd("R11 reasserted", 8'h04, 32'h04);
    chk_irq("R10 irq back", 1);
    wr(8'h0C, 32'h04);
  endtask

  task automatic t_rx;
    rx_level = 6'd1; tick();
    chk_rd("R6 R7 rx one entry", 8'h04, 32'h1C);
    wr(8'h2C, 32'h05);
    wr(8'h04, 32'h7F); tick(2);
    chk_rd("R6 rx below thr", 8'h04, 32'h14);
    rx_level = 6'd5; tick();
    chk_rd("R7 rx at thr", 8'h04, 32'h1C);
    rx_level = 6'd0; wr(8'h04, 32'h18); tick(2);
    chk_rd("R6 rx empty", 8'h04, 32'h04);
  endtask

  task automatic t_thr_width;
    wr(8'h2C, 32'hFFFF_FFC7);
    chk_rd("R9 rxthr six bits", 8'h2C, 32'h07);
    wr(8'h28, 32'h0000_0140);
    chk_rd("R9 txthr six bits", 8'h28, 32'h00);
  endtask

  initial begin
    tick(2);
    t_reset();
    tick(); rst_n = 1; tick();
    t_map();
    t_events();
    t_w1c();
    t_mask();
    t_tx();
    t_reassert();
    t_rx();
    t_thr_width();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20ns * 100000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule